// File: doc/BRIEF.md
# Inbound Bus Command Translator

This block sits between the target-side front end of a PCI-style bridge and the master port of an on-chip system bus. The front end hands it one decoded inbound transaction at a time: a command code, an address, a 4-bit byte-enable vector and a beat count. The block decides whether the transaction is claimed and, if it is, presents one outbound request, or a short series of them, to the system bus master. Each outbound request carries a direction, a size code, a beat count, an address and byte enables. The block never produces cache-line transfers.

A transaction is claimed only when the global memory-enable input is set and the address falls inside one of two programmable windows. Each window is a base and a size mask. Line-oriented and multiple-line reads become word burst reads. Plain reads become single-beat reads. Writes become single-beat or word burst writes. A burst write whose byte enables have a hole in them is split into one single-beat write per inbound beat. A configuration cycle that the bridge issues to itself ends in a one-cycle master-abort pulse. All other command codes are accepted and dropped.

The control is a four-state machine:
- **IDLE** raises `req_ready`. On accept it goes to ISSUE (a single or burst request), to SPLIT (a non-contiguous burst write), to ABORT (a self-targeted configuration cycle), or stays in IDLE (the request is not claimed).
- **ISSUE** holds `out_valid` until `out_ack`, then returns to IDLE.
- **SPLIT** presents single-beat writes at successive word addresses. Each `out_ack` moves to the next beat, and it returns to IDLE after the last one.
- **ABORT** lasts one cycle, raises `mst_abort`, and returns to IDLE.

Top module: `inb_cmd_xlate`

## Requirements
- R1: A memory command is claimed only when `mem_en` is 1 and the address hits window 0 or window 1. When both windows hit, `out_win` reports 0; otherwise it reports the window that hit.
- R2: Window i hits when `win_mask[i]` is nonzero and `(addr & win_mask[i]) == (win_base[i] & win_mask[i])`. A window whose mask is zero never hits.
- R3: A claimed memory read (command 4'h6) produces one read with `out_rnw`=1, `out_size`=4'b0000 and `out_beats`=1, whatever the inbound length.
- R4: A claimed read multiple (4'hC) or read line (4'hE) produces one read with `out_size`=4'b1010 and `out_beats` equal to the inbound length.
- R5: A claimed memory write (4'h7) or write-and-invalidate (4'hF) with length 1 produces one write with `out_rnw`=0, `out_size`=4'b0000, `out_beats`=1 and the inbound byte enables.
- R6: A claimed 4'h7 or 4'hF write with length of 2 or more and contiguous byte enables (the 1 bits form one run; bit i enables byte i) produces one write with `out_size`=4'b1010 and `out_beats` equal to the length. The two commands give identical outbound requests.
- R7: A claimed write with length N of 2 or more and non-contiguous byte enables produces N single-beat writes, in order, at addresses addr, addr+4, …, addr+4(N-1). Each write carries the same byte enables, and each one waits for its own `out_ack`.
- R8: `out_size` is only ever 4'b0000 or 4'b1010 while `out_valid` is 1. No line-sized code is ever issued.
- R9: A configuration command (4'hA or 4'hB) with `req_self`=1 raises `mst_abort` for exactly one cycle, starting the cycle after acceptance. It produces no outbound request.
- R10: I/O commands (4'h2, 4'h3), configuration commands with `req_self`=0, and other codes are accepted and produce neither an outbound request nor `mst_abort`.
- R11: After reset, `req_ready`=1, `out_valid`=0 and `mst_abort`=0. `req_ready` is 1 only while no request is in flight. An outbound request appears the cycle after acceptance and holds all its fields until `out_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | input | 1 | Global memory-access enable |
| win_base | input | 2x32 | Base address of each window |
| win_mask | input | 2x32 | Size mask of each window (zero disables the window) |
| req_valid | input | 1 | Inbound request valid |
| req_ready | output | 1 | Block can accept a request |
| req_cmd | input | 4 | Inbound command code |
| req_addr | input | 32 | Inbound address |
| req_be | input | 4 | Inbound byte enables, 1 = enabled |
| req_len | input | 5 | Inbound beat count |
| req_self | input | 1 | Request was initiated by the bridge itself |
| out_valid | output | 1 | Outbound request valid |
| out_ack | input | 1 | Outbound request accepted |
| out_rnw | output | 1 | 1 = read, 0 = write |
| out_size | output | 4 | 4'b0000 single beat, 4'b1010 word burst |
| out_beats | output | 5 | Beats in the outbound request |
| out_addr | output | 32 | Outbound address |
| out_be | output | 4 | Outbound byte enables |
| out_win | output | 1 | Index of the window that claimed the request |
| mst_abort | output | 1 | One-cycle master-abort pulse |

## Verification
The bench targets these corner cases, and what each wrong design would do:
- **Split burst write.** A burst write with a hole in its byte enables must come out as a series of single-beat writes. A design that skips the split would issue a word burst write. One that miscounts would issue too few or too many beats, or step the address wrongly.
- **Plain burst read.** This must stay a single-beat read. A design that treats it like a line read would return a burst size code.
- **Overlapping windows.** When both windows hit, `out_win` must report 0. Wrong priority would report window 1.
- **Zero mask.** A window with a zero mask must never hit. A design that ignores this would claim every address for that window.
- **Memory enable low.** A design that ignores `mem_en` would claim in-window accesses while it is low.
- **Self-targeted configuration cycle.** A design that drops the abort would show no `mst_abort` pulse. One that holds the abort would keep `req_ready` low too long.
- **Stalled bus.** A stall on `out_ack` must leave `out_valid` and the request fields frozen, with no new request accepted. A design that breaks this would drop the request or accept another.

// File: rtl/inb_xlate_pkg.sv
package inb_xlate_pkg;

    localparam logic [3:0] CMD_IO_RD   = 4'h2;
    localparam logic [3:0] CMD_IO_WR   = 4'h3;
    localparam logic [3:0] CMD_MEM_RD  = 4'h6;
    localparam logic [3:0] CMD_MEM_WR  = 4'h7;
    localparam logic [3:0] CMD_CFG_RD  = 4'hA;
    localparam logic [3:0] CMD_CFG_WR  = 4'hB;
    localparam logic [3:0] CMD_RD_MULT = 4'hC;
    localparam logic [3:0] CMD_RD_LINE = 4'hE;
    localparam logic [3:0] CMD_MWI     = 4'hF;

    localparam logic [3:0] SZ_SINGLE = 4'b0000;
    localparam logic [3:0] SZ_WBURST = 4'b1010;

    typedef enum logic [2:0] {
        XK_NONE,
        XK_RD1,
        XK_RDB,
        XK_WR1,
        XK_WRB,
        XK_SPLIT,
        XK_ABORT
    } xkind_e;

    // True when the set bits of be form a single run (or be is zero)
    function automatic logic be_contig(input logic [3:0] be);
        logic [4:0] x;
        logic [4:0] low;
        x   = {1'b0, be};
        low = x & (~x + 5'd1);
        return ((x + low) & x) == 5'd0;
    endfunction

endpackage

// File: rtl/inb_win_decode.sv
module inb_win_decode #(
    parameter int AW   = 32,
    parameter int NWIN = 2,
    parameter int WIDX = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [NWIN-1:0][AW-1:0] win_base,
    input  logic [NWIN-1:0][AW-1:0] win_mask,
    input  logic [AW-1:0]           addr,
    output logic                    any_hit,
    output logic [WIDX-1:0]         hit_idx
);

    logic [NWIN-1:0] hit;

    generate
        for (genvar i = 0; i < NWIN; i++) begin : g_win
            assign hit[i] = (win_mask[i] != '0) &&
                            ((addr & win_mask[i]) == (win_base[i] & win_mask[i]));
        end
    endgenerate

    // Lowest-numbered window wins when several hit
    always_comb begin
        hit_idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) hit_idx = WIDX'(i);
        end
    end

    assign any_hit = |hit;

endmodule

// File: rtl/inb_cmd_map.sv
module inb_cmd_map
    import inb_xlate_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic [3:0]    cmd,
    input  logic [3:0]    be,
    input  logic [LW-1:0] len,
    input  logic          mem_en,
    input  logic          hit,
    input  logic          self_req,
    output xkind_e        kind
);

    logic claim;
    logic multi;

    assign claim = mem_en && hit;
    assign multi = len > LW'(1);

    always_comb begin
        kind = XK_NONE;
        case (cmd)
            CMD_MEM_RD:               kind = claim ? XK_RD1 : XK_NONE;
            CMD_RD_MULT, CMD_RD_LINE: kind = claim ? XK_RDB : XK_NONE;
            CMD_MEM_WR, CMD_MWI: begin
                if (!claim)             kind = XK_NONE;
                else if (!multi)        kind = XK_WR1;
                else if (be_contig(be)) kind = XK_WRB;
                else                    kind = XK_SPLIT;
            end
            CMD_CFG_RD, CMD_CFG_WR:   kind = self_req ? XK_ABORT : XK_NONE;
            default:                  kind = XK_NONE;
        endcase
    end

endmodule

// File: rtl/inb_cmd_xlate.sv
module inb_cmd_xlate
    import inb_xlate_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LW   = 5,
    parameter int NWIN = 2,
    parameter int WIDX = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mem_en,
    input  logic [NWIN-1:0][AW-1:0] win_base,
    input  logic [NWIN-1:0][AW-1:0] win_mask,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [3:0]              req_cmd,
    input  logic [AW-1:0]           req_addr,
    input  logic [3:0]              req_be,
    input  logic [LW-1:0]           req_len,
    input  logic                    req_self,
    output logic                    out_valid,
    input  logic                    out_ack,
    output logic                    out_rnw,
    output logic [3:0]              out_size,
    output logic [LW-1:0]           out_beats,
    output logic [AW-1:0]           out_addr,
    output logic [3:0]              out_be,
    output logic [WIDX-1:0]         out_win,
    output logic                    mst_abort
);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_SPLIT, S_ABORT} st_e;

    st_e             st, st_nxt;
    xkind_e          kind;
    logic            any_hit;
    logic [WIDX-1:0] hit_idx;
    logic            accept;
    logic            last_beat;
    logic [LW-1:0]   len_eff;

    logic            k_rnw;
    logic            k_burst;
    logic [AW-1:0]   k_addr;
    logic [3:0]      k_be;
    logic [LW-1:0]   k_beats;
    logic [WIDX-1:0] k_win;
    logic [LW-1:0]   cnt;

    inb_win_decode #(.AW(AW), .NWIN(NWIN), .WIDX(WIDX)) u_dec (
        .win_base (win_base),
        .win_mask (win_mask),
        .addr     (req_addr),
        .any_hit  (any_hit),
        .hit_idx  (hit_idx)
    );

    inb_cmd_map #(.LW(LW)) u_map (
        .cmd      (req_cmd),
        .be       (req_be),
        .len      (req_len),
        .mem_en   (mem_en),
        .hit      (any_hit),
        .self_req (req_self),
        .kind     (kind)
    );

    assign accept    = req_valid && (st == S_IDLE);
    assign last_beat = (cnt == k_beats - LW'(1));
    assign len_eff   = (req_len == '0) ? LW'(1) : req_len;

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE: begin
                if (accept) begin
                    unique case (kind)
                        XK_NONE:  st_nxt = S_IDLE;
                        XK_ABORT: st_nxt = S_ABORT;
                        XK_SPLIT: st_nxt = S_SPLIT;
                        default:  st_nxt = S_ISSUE;
                    endcase
                end
            end
            S_ISSUE: if (out_ack) st_nxt = S_IDLE;
            S_SPLIT: if (out_ack && last_beat) st_nxt = S_IDLE;
            S_ABORT: st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_rnw   <= 1'b0;
            k_burst <= 1'b0;
            k_addr  <= '0;
            k_be    <= '0;
            k_beats <= '0;
            k_win   <= '0;
            cnt     <= '0;
        end else if (accept) begin
            k_rnw   <= (kind == XK_RD1) || (kind == XK_RDB);
            k_burst <= (kind == XK_RDB) || (kind == XK_WRB);
            k_addr  <= req_addr;
            k_be    <= req_be;
            k_beats <= (kind == XK_RD1 || kind == XK_WR1) ? LW'(1) : len_eff;
            k_win   <= hit_idx;
            cnt     <= '0;
        end else if (st == S_SPLIT && out_ack) begin
            cnt <= cnt + LW'(1);
        end
    end

    always_comb begin
        req_ready = (st == S_IDLE);
        out_valid = (st == S_ISSUE) || (st == S_SPLIT);
        mst_abort = (st == S_ABORT);
        out_rnw   = k_rnw;
        out_size  = k_burst ? SZ_WBURST : SZ_SINGLE;
        out_beats = (st == S_SPLIT) ? LW'(1) : k_beats;
        out_addr  = k_addr + AW'({cnt, 2'b00});
        out_be    = k_be;
        out_win   = k_win;
    end

    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> out_valid && $stable(out_addr) &&
        $stable(out_size) && $stable(out_beats) && $stable(out_rnw));

    // R7
    split_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_rnw && !be_contig(out_be) |->
        out_size == SZ_SINGLE && out_beats == LW'(1));

    // R8
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_size == SZ_SINGLE) || (out_size == SZ_WBURST));

    // R9
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_abort |=> !mst_abort && req_ready && !out_valid);

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_rnw && out_size == SZ_SINGLE |-> out_beats == LW'(1));

endmodule

// File: tb/inb_cmd_xlate_tb.sv
module inb_cmd_xlate_tb;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mem_en = 1'b1;
    logic [1:0][31:0] win_base;
    logic [1:0][31:0] win_mask;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [3:0]       req_cmd = '0;
    logic [31:0]      req_addr = '0;
    logic [3:0]       req_be = '0;
    logic [4:0]       req_len = '0;
    logic             req_self = 1'b0;
    logic             out_valid;
    logic             out_ack = 1'b0;
    logic             out_rnw;
    logic [3:0]       out_size;
    logic [4:0]       out_beats;
    logic [31:0]      out_addr;
    logic [3:0]       out_be;
    logic [0:0]       out_win;
    logic             mst_abort;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    inb_cmd_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en),
        .win_base(win_base), .win_mask(win_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_be(req_be), .req_len(req_len),
        .req_self(req_self), .out_valid(out_valid), .out_ack(out_ack),
        .out_rnw(out_rnw), .out_size(out_size), .out_beats(out_beats),
        .out_addr(out_addr), .out_be(out_be), .out_win(out_win),
        .mst_abort(mst_abort)
    );

    // kind: 0 none, 1 single read, 2 burst read, 3 single write, 4 burst write
    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [4:0]  len;
        logic [2:0]  kind;
        logic        win;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'h6, 32'h1000_0010, 4'hF, 5'd1, 3'd1, 1'b0, 4'd3},  // R3
        '{4'h6, 32'h1000_0020, 4'hF, 5'd8, 3'd1, 1'b0, 4'd3},  // R3 burst still single
        '{4'hC, 32'h2000_4000, 4'hF, 5'd8, 3'd2, 1'b1, 4'd4},  // R4
        '{4'hE, 32'h1000_0000, 4'hF, 5'd4, 3'd2, 1'b0, 4'd4},  // R4
        '{4'h7, 32'h2000_0100, 4'h3, 5'd1, 3'd3, 1'b1, 4'd5},  // R5
        '{4'hF, 32'h1000_0040, 4'hF, 5'd1, 3'd3, 1'b0, 4'd5},  // R5
        '{4'h7, 32'h2000_0200, 4'hF, 5'd6, 3'd4, 1'b1, 4'd6},  // R6
        '{4'hF, 32'h1000_0080, 4'h6, 5'd4, 3'd4, 1'b0, 4'd6},  // R6
        '{4'h6, 32'h3000_0000, 4'hF, 5'd1, 3'd0, 1'b0, 4'd1},  // R1 miss
        '{4'h2, 32'h1000_0000, 4'hF, 5'd1, 3'd0, 1'b0, 4'd10}, // R10 io read
        '{4'h3, 32'h1000_0000, 4'hF, 5'd1, 3'd0, 1'b0, 4'd10}, // R10 io write
        '{4'hA, 32'h1000_0000, 4'hF, 5'd1, 3'd0, 1'b0, 4'd10}  // R10 config not self
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                        input logic [4:0] l, input logic s);
        @(negedge clk);
        req_cmd = c; req_addr = a; req_be = b; req_len = l; req_self = s;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic rnw, input logic [3:0] sz,
                              input logic [4:0] bt, input logic [31:0] a,
                              input logic [3:0] b, input logic w);
        chk(tag, {out_valid, out_rnw, out_size, out_beats, out_be, out_win, req_ready},
                 {1'b1, rnw, sz, bt, b, w, 1'b0});
        chk(tag, out_addr, a);
        // R8: only the single or word burst size code may appear
        chk("R8", 64'(out_size == 4'b0000 || out_size == 4'b1010), 64'd1);
        out_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ack = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        chk(tag, {out_valid, mst_abort, req_ready}, 3'b001);
        @(negedge clk);
        chk(tag, {out_valid, mst_abort, req_ready}, 3'b001);
    endtask

    initial begin
        win_base[0] = 32'h1000_0000; win_mask[0] = 32'hFFFF_F000;
        win_base[1] = 32'h2000_0000; win_mask[1] = 32'hFFF0_0000;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset", {req_ready, out_valid, mst_abort}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle", {req_ready, out_valid, mst_abort}, 3'b100);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v.rq, i);
            send(v.cmd, v.addr, v.be, v.len, 1'b0);
            if (v.kind == 3'd0)
                expect_none(tag);
            else
                expect_out(tag, v.kind <= 3'd2,
                           (v.kind == 3'd2 || v.kind == 3'd4) ? 4'b1010 : 4'b0000,
                           (v.kind == 3'd2 || v.kind == 3'd4) ? v.len : 5'd1,
                           v.addr, v.be, v.win);
        end

        // R11 request held while out_ack stays low
        send(4'h6, 32'h1000_0004, 4'h1, 5'd1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            chk("R11 hold", {out_valid, req_ready, out_addr}, {1'b1, 1'b0, 32'h1000_0004});
            @(negedge clk);
        end
        expect_out("R11 hold release", 1'b1, 4'b0000, 5'd1, 32'h1000_0004, 4'h1, 1'b0);
        expect_none("R11 back idle");

        // R7 non-contiguous burst write splits into single beats
        send(4'h7, 32'h1000_0100, 4'b0101, 5'd3, 1'b0);
        for (int k = 0; k < 3; k++)
            expect_out("R7 split", 1'b0, 4'b0000, 5'd1, 32'h1000_0100 + 32'(4 * k), 4'b0101, 1'b0);
        expect_none("R7 split end");

        // R9 self-targeted configuration cycles abort
        send(4'hB, 32'h0000_0800, 4'hF, 5'd1, 1'b1);
        chk("R9 abort pulse", {mst_abort, out_valid, req_ready}, 3'b100);
        @(negedge clk);
        chk("R9 abort end", {mst_abort, out_valid, req_ready}, 3'b001);
        send(4'hA, 32'h0000_0800, 4'hF, 5'd1, 1'b1);
        chk("R9 abort cfg rd", {mst_abort, out_valid}, 2'b10);
        @(negedge clk);

        // R1 memory enable off blocks an in-window read
        mem_en = 1'b0;
        send(4'h6, 32'h1000_0010, 4'hF, 5'd1, 1'b0);
        expect_none("R1 mem_en off");
        mem_en = 1'b1;

        // R2 zero mask disables window 1
        win_mask[1] = 32'h0;
        send(4'h7, 32'h2000_0000, 4'hF, 5'd1, 1'b0);
        expect_none("R2 zero mask");

        // R1 overlap: window 0 has priority
        win_base[1] = 32'h1000_0000; win_mask[1] = 32'hFFFF_0000;
        send(4'hE, 32'h1000_0010, 4'hF, 5'd2, 1'b0);
        expect_out("R1 overlap", 1'b1, 4'b1010, 5'd2, 32'h1000_0010, 4'hF, 1'b0);
        // R2 window 1 alone on its larger range
        send(4'h6, 32'h1000_8000, 4'h8, 5'd1, 1'b0);
        expect_out("R2 win1 hit", 1'b1, 4'b0000, 5'd1, 32'h1000_8000, 4'h8, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule